// File: doc/BRIEF.md
# Strobe-Captured Word Serializer

This block takes a 10-bit parallel word, captures it when the strobe input rises, and sends it as a serial frame. A forwarded bit clock goes out with the data. The block runs on one fast clock. A bit-slot enable advances the serial side by one slot per pulse, and twelve slots make one frame, so one frame lasts one reference-clock period. Each data frame has three parts: a start marker at 1, the ten data bits least significant first, and a stop marker at 0. When no word is waiting, the block sends an idle frame with the start marker at 0, the data slots at 0 and the stop marker at 1.

A 2-bit ratio code tells the block how fast the strobe runs compared with the reference. Data may go out in every frame, every second frame or every third frame, counted from the first frame after reset or after leaving power-down. A captured word waits in a one-word holding register until the next frame that may carry data. A 2-bit mode code of 00 puts the block in power-down. Power-down clears all state, disables the serial outputs and parks the forwarded clock high. The direction output always shows the inverse of the direction input.

Top module: `strobed_word_serializer`

## Requirements
- R1: A rising edge of `strobe`, sampled on `clk`, captures `pdata`. The captured word goes out in the next eligible frame. Frame slot order is: slot 0 carries 1, slots 1 to 10 carry `pdata[0]` to `pdata[9]`, and slot 11 carries 0.
- R2: Each `clk` cycle with `bit_en` high advances one slot, and a frame has 12 slots. `ser_clk` is high after reset and after leaving power-down, and it inverts on every slot.
- R3: A frame sent with no word waiting is idle: slot 0 is 0, slots 1 to 10 are 0, and slot 11 is 1.
- R4: Frames are numbered from 0 starting with the first frame after reset or after leaving power-down. With `ratio` at 01 or 00, every frame may carry data. With 10, only even-numbered frames may. With 11, only frames numbered a multiple of three may. A waiting word is held until an eligible frame starts.
- R5: A capture while a word is still waiting replaces that word. `overrun` then goes high for exactly one `clk` cycle, and the newer word is the one sent.
- R6: A capture into an empty holding register leaves `overrun` low.
- R7: `mode` of 00 drives `ser_oe` low, `ser_clk` high and `ser_dat` low in the same cycle. In power-down, strobe edges are ignored and any waiting word is dropped.
- R8: Leaving power-down restarts cleanly. Framing begins at slot 0 of frame 0, and a strobe already high when power-down ends is not counted as an edge.
- R9: `dir_out` is the inverse of `dir_in` in every mode, including power-down.
- R10: While `bit_en` is low, `ser_dat` and `ser_clk` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advances the frame by one slot |
| strobe | input | 1 | Word capture strobe, active on its rising edge |
| pdata | input | 10 | Parallel data word |
| ratio | input | 2 | Strobe-to-reference ratio code |
| mode | input | 2 | Operating range code; 00 selects power-down |
| dir_in | input | 1 | Direction select |
| ser_dat | output | 1 | Serial data, one bit per slot |
| ser_clk | output | 1 | Forwarded bit clock |
| ser_oe | output | 1 | Serial driver enable |
| overrun | output | 1 | One-cycle pulse when a waiting word is replaced |
| dir_out | output | 1 | Inverse of `dir_in` |

## Verification
A slot counter that drifts shows up within one frame: the start or stop marker lands in the wrong slot, and a compare of the whole frame catches it. A wrong frame phase under ratio 2 or 3 shows up as a data frame where an idle frame was due, or as an idle frame where data was due. That is visible at the first eligible frame after the strobe. Holding-register faults appear as a word that is never sent, a stale word, or a missing or extra `overrun` pulse on the cycle after the strobe edge. Incomplete clearing in power-down becomes visible in the first frame after power-down ends.

// File: rtl/strobed_word_serializer.sv
module strobed_word_serializer #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          strobe,
  input  logic [DW-1:0] pdata,
  input  logic [1:0]    ratio,
  input  logic [1:0]    mode,
  input  logic          dir_in,
  output logic          ser_dat,
  output logic          ser_clk,
  output logic          ser_oe,
  output logic          overrun,
  output logic          dir_out
);
  localparam int SLOTS = DW + 2;
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] PRE_STOP = SW'(SLOTS - 2);

  logic          stb_q, hold_v, dframe_q, dat_q, clk_q, ovr_q;
  logic [DW-1:0] hold_q, sh_q;
  logic [SW-1:0] slot_q;
  logic [1:0]    ph_q;

  wire       pd     = (mode == 2'b00);
  wire [1:0] ph_max = (ratio == 2'b10) ? 2'd1 : (ratio == 2'b11) ? 2'd2 : 2'd0;
  wire       cap    = strobe & ~stb_q;
  wire       wrap   = bit_en & (slot_q == LAST);
  wire [1:0] ph_nxt = (ph_q >= ph_max) ? 2'd0 : ph_q + 2'd1;
  wire       launch = wrap & hold_v & (ph_nxt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b1; hold_v <= 1'b0; hold_q <= '0; sh_q <= '0;
      slot_q <= LAST; ph_q <= 2'd3; dframe_q <= 1'b0;
      dat_q <= 1'b0; clk_q <= 1'b1; ovr_q <= 1'b0;
    end else if (pd) begin
      stb_q <= 1'b1; hold_v <= 1'b0; hold_q <= '0; sh_q <= '0;
      slot_q <= LAST; ph_q <= 2'd3; dframe_q <= 1'b0;
      dat_q <= 1'b0; clk_q <= 1'b1; ovr_q <= 1'b0;
    end else begin
      stb_q <= strobe;
      ovr_q <= cap & hold_v & ~launch;
      if (cap) begin
        hold_q <= pdata;
        hold_v <= 1'b1;
      end else if (launch) begin
        hold_v <= 1'b0;
      end
      if (bit_en) begin
        clk_q <= ~clk_q;
        if (wrap) begin
          slot_q   <= '0;
          ph_q     <= ph_nxt;
          dframe_q <= launch;
          dat_q    <= launch;
          if (launch) sh_q <= hold_q;
        end else begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == PRE_STOP) begin
            dat_q <= ~dframe_q;
          end else begin
            dat_q <= dframe_q & sh_q[0];
            sh_q  <= sh_q >> 1;
          end
        end
      end
    end
  end

  assign ser_dat = dat_q & ~pd;
  assign ser_clk = clk_q | pd;
  assign ser_oe  = ~pd;
  assign overrun = ovr_q;
  assign dir_out = ~dir_in;

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n || pd)
    !bit_en |=> $stable(dat_q) && $stable(clk_q));

  // R2
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || pd)
    bit_en |=> clk_q != $past(clk_q));

  // R1
  hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n || pd)
    $rose(hold_v) |-> $past(strobe));

  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> $past(hold_v));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n || pd)
    wrap |=> ph_q <= ph_max);

  // R3
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n || pd)
    bit_en && slot_q == PRE_STOP |=> dat_q != dframe_q);

  // R7
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !hold_v && !dframe_q && !ovr_q);
endmodule

// File: tb/strobed_word_serializer_test.sv
module strobed_word_serializer_test;
  localparam int DW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, bit_en, strobe, dir_in;
  logic [DW-1:0] pdata;
  logic [1:0]    ratio, mode;
  logic          ser_dat, ser_clk, ser_oe, overrun, dir_out;

  int checks = 0, fails = 0, fcount = 0, nslots = 0;
  bit done = 1'b0;

  strobed_word_serializer #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .strobe(strobe), .pdata(pdata),
    .ratio(ratio), .mode(mode), .dir_in(dir_in), .ser_dat(ser_dat),
    .ser_clk(ser_clk), .ser_oe(ser_oe), .overrun(overrun), .dir_out(dir_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ratio_n(input logic [1:0] r);
    return (r == 2'b10) ? 2 : (r == 2'b11) ? 3 : 1;
  endfunction

  task automatic get_frame(output logic [11:0] v, output bit clk_ok, output bit stall_ok);
    clk_ok = 1'b1;
    stall_ok = 1'b1;
    for (int k = 0; k < 12; k++) begin
      logic d, c;
      bit_en = 1'b1;
      step();
      bit_en = 1'b0;
      d = ser_dat;
      c = ser_clk;
      v[k] = d;
      nslots++;
      if (c != ((nslots % 2) == 0)) clk_ok = 1'b0;
      step();
      if (ser_dat != d || ser_clk != c) stall_ok = 1'b0;
    end
  endtask

  task automatic strobe_w(input logic [DW-1:0] d, output logic ov);
    pdata = d;
    strobe = 1'b1;
    step();
    ov = overrun;
    strobe = 1'b0;
    step();
    chk(overrun == 1'b0, "R5 overrun single cycle", overrun, 0);
  endtask

  task automatic expect_frames(input bit have, input logic [DW-1:0] d, input string req);
    bit stop = 1'b0;
    while (!stop) begin
      logic [11:0] v, e;
      bit cok, sok;
      bit isdata;
      isdata = have && ((fcount % ratio_n(ratio)) == 0);
      e = isdata ? {1'b0, d, 1'b1} : 12'h800;
      get_frame(v, cok, sok);
      chk(v == e, isdata ? req : "R3 idle frame", v, e);
      chk(cok, "R2 forwarded clock parity", 0, 1);
      chk(sok, "R10 hold while bit_en low", 0, 1);
      fcount++;
      if (isdata || !have) stop = 1'b1;
    end
  endtask

  task automatic pd_cycle(input logic [1:0] r, input logic [1:0] m);
    mode = 2'b00;
    ratio = r;
    step();
    step();
    chk(ser_oe == 1'b0 && ser_clk == 1'b1 && ser_dat == 1'b0, "R7 power-down outputs",
        {ser_oe, ser_clk, ser_dat}, 3'b010);
    mode = m;
    fcount = 0;
    nslots = 0;
    step();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ov;
    logic [DW-1:0] d;
    logic [1:0] rs [4];
    rst_n = 1'b0; bit_en = 1'b0; strobe = 1'b0; dir_in = 1'b1;
    pdata = '0; ratio = 2'b01; mode = 2'b01;
    @(negedge clk);
    step();
    step();
    rst_n = 1'b1;
    step();

    chk(ser_clk == 1'b1 && ser_dat == 1'b0 && ser_oe == 1'b1 && overrun == 1'b0,
        "R2 reset outputs", {ser_clk, ser_dat, ser_oe, overrun}, 4'b1010);
    chk(dir_out == 1'b0, "R9 dir_out with dir_in=1", dir_out, 0);
    expect_frames(1'b0, '0, "R3");

    rs[0] = 2'b01; rs[1] = 2'b00; rs[2] = 2'b10; rs[3] = 2'b11;
    for (int ri = 0; ri < 4; ri++) begin
      pd_cycle(rs[ri], 2'(ri % 3 + 1));
      for (int i = 0; i < 20; i++) begin
        if (i % 5 == 4) begin
          expect_frames(1'b0, '0, "R3");
        end else begin
          d = (i == 1) ? 10'h3FF : DW'((i * 97 + ri * 31 + 5) & 10'h3FF);
          strobe_w(d, ov);
          chk(ov == 1'b0, "R6 no overrun into empty hold", ov, 0);
          expect_frames(1'b1, d, rs[ri] == 2'b01 ? "R1 data frame" : "R4 ratio framing");
        end
      end
    end

    pd_cycle(2'b01, 2'b01);
    strobe_w(10'h155, ov);
    chk(ov == 1'b0, "R6 first capture", ov, 0);
    strobe_w(10'h2A3, ov);
    chk(ov == 1'b1, "R5 overrun on replace", ov, 1);
    expect_frames(1'b1, 10'h2A3, "R5 newest word sent");
    expect_frames(1'b0, '0, "R3");

    pd_cycle(2'b11, 2'b10);
    expect_frames(1'b0, '0, "R3");
    strobe_w(10'h0F1, ov);
    expect_frames(1'b1, 10'h0F1, "R4 ratio 3 wait");

    pd_cycle(2'b01, 2'b01);
    strobe_w(10'h3C3, ov);
    bit_en = 1'b1;
    step();
    bit_en = 1'b0;
    chk(ser_clk == 1'b0, "R2 clock low after one slot", ser_clk, 0);
    mode = 2'b00;
    #1;
    chk(ser_clk == 1'b1 && ser_oe == 1'b0 && ser_dat == 1'b0, "R7 immediate power-down",
        {ser_clk, ser_oe, ser_dat}, 3'b100);
    chk(dir_out == 1'b0, "R9 dir_out in power-down", dir_out, 0);
    step();
    strobe_w(10'h111, ov);
    chk(ov == 1'b0, "R7 strobe ignored in power-down", ov, 0);
    strobe = 1'b1;
    pdata = 10'h222;
    step();
    mode = 2'b11;
    fcount = 0;
    nslots = 0;
    step();
    step();
    expect_frames(1'b0, '0, "R8");
    chk(1'b1, "R8 restart frame checked above", 1, 1);
    strobe = 1'b0;
    step();
    strobe_w(10'h099, ov);
    expect_frames(1'b1, 10'h099, "R8 clean restart data");

    dir_in = 1'b0;
    #1;
    chk(dir_out == 1'b1, "R9 dir_out with dir_in=0", dir_out, 1);
    mode = 2'b00;
    #1;
    chk(dir_out == 1'b1, "R9 dir_out power-down dir_in=0", dir_out, 1);
    mode = 2'b01;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule